// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a bank of general-purpose input pins (thirty-two by default) and turns activity on them into a single interrupt request toward the processor. Each pin can be programmed to react to a level of either polarity, or to rising edges, falling edges or both. Its pending flag either follows the live condition or latches until software clears it. The pins are grouped into 16-bit halves so that every control can be read and written through a narrow 16-bit register port.

Pending flags are gated by per-pin enables. Their OR drives the cascade interrupt output. A priority encoder reports the number of the lowest requesting pin, with a valid flag. The encoder searches the low half before the high half. Pin inputs are assumed asynchronous, so they pass through a two-stage synchroniser before any detection. A direction-select register is kept for software but drives nothing.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with all pins held high, every register reads 0 and `irq_o` and `pin_valid_o` are 0. The synchroniser stages reset to 1.
- R2: Registers use byte addresses. Bit 1 selects the half (0 = pins 0-15, 1 = pins 16-31) and bits 4:2 select the register: 0 status, 1 enable, 2 trigger mode, 3 polarity, 4 hold, 5 rising-edge qualify, 6 falling-edge qualify, 7 direction. The direction register reads back what was written and changes no output.
- R3: In level mode (mode bit 0) a pin's status follows its input: it is set while the input is high if the polarity bit is 1, and set while the input is low if the polarity bit is 0.
- R4: In edge mode (mode bit 1) an event is a rising edge with the rise-qualify bit set, or a falling edge with the fall-qualify bit set. With the hold bit 0, status is high for exactly one cycle per event.
- R5: In edge mode with the hold bit 1, an event sets the status bit and it stays set until a 1 is written to that bit. Writing 0 leaves it unchanged.
- R6: If an event and a write-1-to-clear reach the same status bit in the same cycle, the bit stays set.
- R7: In level mode the hold bit has no effect: status keeps following the input, and a write-1-to-clear does not latch it low.
- R8: `irq_o` is 1 exactly when some pin has both its status and enable bits at 1. Status remains readable for disabled pins.
- R9: `pin_num_o` gives the lowest requesting pin of the low half. If no pin in the low half is requesting, it gives the lowest requesting pin of the high half, counted from 16. `pin_valid_o` is 0 when nothing is requesting.
- R10: A pin change sets status at the third rising clock edge after the change, two cycles of which are synchroniser delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pins_i | input | 32 | Asynchronous pin inputs |
| irq_o | output | 1 | Cascade interrupt request |
| pin_valid_o | output | 1 | Encoder result valid |
| pin_num_o | output | 5 | Number of the winning pin |

## Verification
On every cycle, the assertions check the following:
- the encoder's valid flag agrees with the cascade request;
- the reported pin is really both pending and enabled;
- a high-half winner only appears when the low half is quiet;
- latched bits that are not being cleared never drop;
- reset empties the status and enable registers.

Only the bench scenarios can show the other behaviours. These are level polarity, per-edge qualification, the one-cycle pulse of a non-holding edge pin, the three-edge latency, the event-beats-clear collision, and the hold bit being ignored in level mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DEF_HALF_W     = 16;
    localparam int DEF_NUM_HALVES = 2;
    localparam int REG_SEL_W      = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_STATUS = 3'd0,
        REG_ENABLE = 3'd1,
        REG_MODE   = 3'd2,
        REG_POL    = 3'd3,
        REG_HOLD   = 3'd4,
        REG_RISE   = 3'd5,
        REG_FALL   = 3'd6,
        REG_DIR    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic edge_mode;
        logic act_high;
        logic hold;
        logic rise_en;
        logic fall_en;
    } pin_cfg_t;

    function automatic logic pin_event(pin_cfg_t c, logic now, logic prev);
        logic rose;
        logic fell;
        rose = now & ~prev;
        fell = ~now & prev;
        if (c.edge_mode)
            return (rose & c.rise_en) | (fell & c.fall_en);
        else
            return c.act_high ? now : ~now;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] now,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] old_q;

    // Stages reset high so idle-high inputs see no edge after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            cur_q  <= '1;
            old_q  <= '1;
        end else begin
            meta_q <= din;
            cur_q  <= meta_q;
            old_q  <= cur_q;
        end
    end

    assign now  = cur_q;
    assign prev = old_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] now,
    input  logic [NPINS-1:0] prev,
    input  pin_cfg_t         cfg [NPINS],
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status_q,
    output logic [NPINS-1:0] latch_eff
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic evt;
        assign evt          = pin_event(cfg[i], now[i], prev[i]);
        // Holding applies only to edge mode; level pins always follow.
        assign latch_eff[i] = cfg[i].edge_mode & cfg[i].hold;

        always_ff @(posedge clk) begin
            if (rst)
                status_q[i] <= 1'b0;
            else if (latch_eff[i])
                status_q[i] <= (status_q[i] & ~clr[i]) | evt;
            else
                status_q[i] <= evt;
        end
    end
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
    parameter int NPINS = 32,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic [NPINS-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] num
);
    // Low half bits sit below high half bits, so lowest overall index
    // gives low-half-first priority.
    always_comb begin
        valid = 1'b0;
        num   = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                num   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W     = DEF_HALF_W,
    parameter int NUM_HALVES = DEF_NUM_HALVES,
    parameter int ADDR_W     = 6
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   bus_we,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic [HALF_W-1:0]                      bus_wdata,
    output logic [HALF_W-1:0]                      bus_rdata,
    input  logic [HALF_W*NUM_HALVES-1:0]           pins_i,
    output logic                                   irq_o,
    output logic                                   pin_valid_o,
    output logic [$clog2(HALF_W*NUM_HALVES)-1:0]   pin_num_o
);
    localparam int NPINS     = HALF_W * NUM_HALVES;
    localparam int IDX_W     = $clog2(NPINS);
    localparam int HB        = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
    localparam int SEL_LSB   = 1 + HB;
    localparam int UPPER_LSB = SEL_LSB + REG_SEL_W;

    logic [HB-1:0]    half;
    reg_sel_e         sel;
    logic             hit;
    int               half_base;

    assign half      = bus_addr[1 +: HB];
    assign sel       = reg_sel_e'(bus_addr[SEL_LSB +: REG_SEL_W]);
    assign hit       = ((bus_addr >> UPPER_LSB) == '0) && !bus_addr[0];
    assign half_base = int'(half) * HALF_W;

    logic [NPINS-1:0] ctl_q [1:7];
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] latch_eff;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] enable_q;
    logic [NPINS-1:0] s_now;
    logic [NPINS-1:0] s_prev;
    logic [NPINS-1:0] req;
    pin_cfg_t         cfg [NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 1; r <= 7; r++) ctl_q[r] <= '0;
        end else if (bus_we && hit && sel != REG_STATUS) begin
            ctl_q[sel][half_base +: HALF_W] <= bus_wdata;
        end
    end

    always_comb begin
        clr_vec = '0;
        if (bus_we && hit && sel == REG_STATUS)
            clr_vec[half_base +: HALF_W] = bus_wdata;
    end

    always_comb begin
        logic [NPINS-1:0] full;
        full = '0;
        if (hit)
            full = (sel == REG_STATUS) ? status_q : ctl_q[sel];
        bus_rdata = full[half_base +: HALF_W];
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        assign cfg[i] = '{edge_mode: ctl_q[REG_MODE][i],
                          act_high:  ctl_q[REG_POL][i],
                          hold:      ctl_q[REG_HOLD][i],
                          rise_en:   ctl_q[REG_RISE][i],
                          fall_en:   ctl_q[REG_FALL][i]};
    end

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_i),
        .now  (s_now),
        .prev (s_prev)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .now       (s_now),
        .prev      (s_prev),
        .cfg       (cfg),
        .clr       (clr_vec),
        .status_q  (status_q),
        .latch_eff (latch_eff)
    );

    assign enable_q = ctl_q[REG_ENABLE];
    assign req      = status_q & enable_q;
    assign irq_o    = |req;

    gpio_irq_prio #(.NPINS(NPINS), .IDX_W(IDX_W)) u_prio (
        .req   (req),
        .valid (pin_valid_o),
        .num   (pin_num_o)
    );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NPINS  = 32,
    parameter int HALF_W = 16,
    parameter int IDX_W  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_o,
    input logic             pin_valid_o,
    input logic [IDX_W-1:0] pin_num_o,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] enable_q,
    input logic [NPINS-1:0] latch_eff,
    input logic [NPINS-1:0] clr_vec
);
    logic [NPINS-1:0] keep_v;
    assign keep_v = status_q & latch_eff & ~clr_vec;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (status_q == '0 && enable_q == '0));

    // R8
    valid_matches_irq_chk: assert property (@(posedge clk) disable iff (rst)
        pin_valid_o == irq_o);

    // R9
    winner_requests_chk: assert property (@(posedge clk) disable iff (rst)
        pin_valid_o |-> (status_q[pin_num_o] && enable_q[pin_num_o]));

    // R9
    low_half_first_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_valid_o && pin_num_o >= IDX_W'(HALF_W))
            |-> ((status_q[HALF_W-1:0] & enable_q[HALF_W-1:0]) == '0));

    // R5
    latched_persist_chk: assert property (@(posedge clk) disable iff (rst)
        (keep_v != '0) |=> ((status_q & $past(keep_v)) == $past(keep_v)));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
    .NPINS  (NPINS),
    .HALF_W (HALF_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_o       (irq_o),
    .pin_valid_o (pin_valid_o),
    .pin_num_o   (pin_num_o),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .latch_eff   (latch_eff),
    .clr_vec     (clr_vec)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
    localparam logic [5:0] ST_L = 6'h00, ST_H = 6'h02, EN_L = 6'h04, EN_H = 6'h06;
    localparam logic [5:0] MD_L = 6'h08, MD_H = 6'h0A, PL_L = 6'h0C, PL_H = 6'h0E;
    localparam logic [5:0] HD_L = 6'h10, HD_H = 6'h12, RS_L = 6'h14;
    localparam logic [5:0] FL_L = 6'h18, DR_L = 6'h1C, DR_H = 6'h1E;

    typedef struct packed {
        logic [31:0] pins;
        logic        irq;
        logic        vld;
        logic [4:0]  num;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h0000_0000, 1'b0, 1'b0, 5'd0},
        '{32'h0000_0001, 1'b1, 1'b1, 5'd0},
        '{32'h8000_0000, 1'b1, 1'b1, 5'd31},
        '{32'h0001_0000, 1'b1, 1'b1, 5'd16},
        '{32'h0001_8000, 1'b1, 1'b1, 5'd15},
        '{32'hFFFF_0000, 1'b1, 1'b1, 5'd16},
        '{32'h0010_0400, 1'b1, 1'b1, 5'd10},
        '{32'h4000_0008, 1'b1, 1'b1, 5'd3},
        '{32'h0000_0004, 1'b1, 1'b1, 5'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pins_i = 32'hFFFF_FFFF;
    logic        irq_o;
    logic        pin_valid_o;
    logic [4:0]  pin_num_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pins_i      (pins_i),
        .irq_o       (irq_o),
        .pin_valid_o (pin_valid_o),
        .pin_num_o   (pin_num_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        chk("R1", "irq in reset", {31'h0, irq_o}, 32'h0);
        rd("R1", ST_L, 16'h0000);
        rst = 1'b0;
        wait_n(4);
        chk("R1", "irq after reset", {31'h0, irq_o}, 32'h0);
        chk("R1", "valid after reset", {31'h0, pin_valid_o}, 32'h0);
        rd("R1", ST_L, 16'h0000);
        rd("R1", ST_H, 16'h0000);
        rd("R1", EN_H, 16'h0000);

        // R2 direction storage round trip, no output effect
        wr(DR_L, 16'hA5A5);
        wr(DR_H, 16'h5A5A);
        rd("R2", DR_L, 16'hA5A5);
        rd("R2", DR_H, 16'h5A5A);
        wait_n(3);
        chk("R2", "irq after dir write", {31'h0, irq_o}, 32'h0);
        rd("R2", ST_L, 16'h0000);

        // Level, active-high, all enabled: walk the table (R3, R8, R9)
        pins_i = 32'h0;
        wait_n(4);
        wr(PL_L, 16'hFFFF);
        wr(PL_H, 16'hFFFF);
        wr(EN_L, 16'hFFFF);
        wr(EN_H, 16'hFFFF);
        foreach (VECS[k]) begin
            pins_i = VECS[k].pins;
            wait_n(4);
            chk("R8", $sformatf("irq vec %0d", k), {31'h0, irq_o}, {31'h0, VECS[k].irq});
            chk("R9", $sformatf("valid vec %0d", k), {31'h0, pin_valid_o}, {31'h0, VECS[k].vld});
            if (VECS[k].vld)
                chk("R9", $sformatf("num vec %0d", k), {27'h0, pin_num_o}, {27'h0, VECS[k].num});
        end
        rd("R3", ST_L, 16'h0004);

        // R3 active-low on low half
        wr(PL_L, 16'h0000);
        wait_n(1);
        rd("R3", ST_L, 16'hFFFB);
        wr(PL_L, 16'hFFFF);
        wait_n(1);

        // R8 disabled pins: status visible, no request
        wr(EN_L, 16'h0000);
        wr(EN_H, 16'h0000);
        wait_n(1);
        rd("R8", ST_L, 16'h0004);
        chk("R8", "irq disabled", {31'h0, irq_o}, 32'h0);
        chk("R9", "spurious valid", {31'h0, pin_valid_o}, 32'h0);

        // R4/R10 edge, rise only, follow
        pins_i = 32'h0;
        wait_n(4);
        wr(MD_L, 16'h0001);
        wr(RS_L, 16'h0001);
        wr(EN_L, 16'h0001);
        @(negedge clk);
        pins_i = 32'h1;
        wait_n(2);
        chk("R10", "irq before third edge", {31'h0, irq_o}, 32'h0);
        wait_n(1);
        chk("R10", "irq at third edge", {31'h0, irq_o}, 32'h1);
        chk("R4", "num rise", {27'h0, pin_num_o}, 32'h0);
        wait_n(1);
        chk("R4", "pulse ends", {31'h0, irq_o}, 32'h0);
        pins_i = 32'h0;
        begin
            int hi = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (irq_o) hi++;
            end
            chk("R4", "fall ignored rise-only", hi, 32'h0);
        end

        // R5 hold latch, both edges
        wr(HD_L, 16'h0001);
        wr(FL_L, 16'h0001);
        @(negedge clk);
        pins_i = 32'h1;
        wait_n(4);
        chk("R5", "latched irq", {31'h0, irq_o}, 32'h1);
        wait_n(10);
        chk("R5", "still latched", {31'h0, irq_o}, 32'h1);
        rd("R5", ST_L, 16'h0001);
        wr(ST_L, 16'h0000);
        rd("R5", ST_L, 16'h0001);
        wr(ST_L, 16'h0001);
        rd("R5", ST_L, 16'h0000);
        chk("R5", "irq after clear", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        pins_i = 32'h0;
        wait_n(4);
        chk("R4", "fall latched both-edge", {31'h0, irq_o}, 32'h1);

        // R6 event and clear in the same cycle
        @(negedge clk);
        pins_i = 32'h1;
        @(negedge clk);
        wr(ST_L, 16'h0001);
        rd("R6", ST_L, 16'h0001);
        wr(ST_L, 16'h0001);
        rd("R6", ST_L, 16'h0000);

        // R7 level mode ignores hold
        wr(HD_H, 16'hFFFF);
        pins_i = 32'h0001_0000;
        wait_n(4);
        rd("R7", ST_H, 16'h0001);
        wr(ST_H, 16'h0001);
        rd("R7", ST_H, 16'h0001);
        pins_i = 32'h0;
        wait_n(4);
        rd("R7", ST_H, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule